// File: doc/BRIEF.md
# Cache-Line Integrity Checksum Store

This block holds the on-die table of integrity checksums for protected memory. Each 128-byte cache line of protected memory has one 16-bit checksum. When a protected line is fetched, the line-fill path presents the whitening value, the physical line address, the checksum it has just computed and the requesting thread number. The block reads the stored checksum and compares the two. Two cycles later it returns a pass or fail pulse, tagged with that thread number. When a protected line is written back, the write path presents the new checksum, and the block stores it over the old entry.

The table index joins two independent fields. The first is a slot number taken from the top bits of the whitening value. The second is a line number taken from the address bits just above the line offset. Because the two fields are independent, any slot can guard any region of memory. A failed comparison stops the requesting thread for good: its halt flag stays set until reset, and the block drops any later fill from that thread. The full-size configuration has 64 slots of 512 lines each, which is 64 KB of storage guarding 4 MB of memory. The defaults use fewer lines per slot.

Top module: `line_crc_store`

## Requirements
- R1: After reset, `res_valid` and every bit of `thread_halt` are 0 and `fill_ready` is 1.
- R2: The table index is {whitening[WHITEN_W-1 -: SLOT_W], address[LINE_LSB +: LINE_W]}. Defaults: the slot is whitening bits 9:4 and the line is address bits 10:7. The low whitening bits and all other address bits have no effect on which entry is used.
- R3: A write-back stores `wb_crc` at its index. A later fill to that index that carries the same checksum returns `res_pass`=1.
- R4: A fill whose checksum differs from the stored entry returns `res_pass`=0.
- R5: A fill issued to the table in cycle T produces a single `res_valid` pulse in cycle T+2, with `res_tid` equal to the fill's thread number.
- R6: Entries with the same line number but different slot numbers are independent. Any slot can be paired with any line.
- R7: When a fill and a write-back arrive in the same cycle, the write takes the table. The fill is held internally and `fill_ready` is 0 for the next cycle. The held fill is issued one cycle late, so its result appears three cycles after the request and reflects the newly written value.
- R8: A fail result sets `thread_halt[res_tid]` in the same cycle as the pulse. The bit stays set until reset, whatever results follow.
- R9: A fill from a thread whose halt bit is set is discarded. It produces no result and changes no halt bit. Other threads are not affected.
- R10: A write-back replaces an older checksum. A fill one cycle after the write already sees the new value, and the old value then fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Line-fill verify request |
| fill_ready | output | 1 | Low for one cycle while a fill is held behind a write |
| fill_whiten | input | WHITEN_W | Whitening value of the filled line |
| fill_addr | input | ADDR_W | Physical address of the filled line |
| fill_crc | input | CRC_W | Checksum computed for the filled line |
| fill_tid | input | TID_W | Requesting thread number |
| wb_valid | input | 1 | Line write-back request |
| wb_whiten | input | WHITEN_W | Whitening value of the written line |
| wb_addr | input | ADDR_W | Physical address of the written line |
| wb_crc | input | CRC_W | New checksum to store |
| res_valid | output | 1 | Verify result pulse |
| res_pass | output | 1 | 1 = checksum matched, 0 = mismatch |
| res_tid | output | TID_W | Thread number of the result |
| thread_halt | output | THREADS | Sticky per-thread halt flags |

## Verification
Fills repeat a stored checksum to separate a correct read from a wrong one, and change a single bit to show that mismatches are caught. Some fills change only the low whitening bits and the out-of-field address bits, which shows that they are outside the index. Others keep the line number and change the slot, which exposes any slot aliasing. The bench also presents a write and a fill to the same entry in one cycle, overwrites an entry and then reads back both the old and the new value, and sends a fill from a halted thread. Together these separate write priority, the serialisation delay, read-after-write order and the sticky halt-and-discard behaviour.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } tbl_op_e;

    localparam int LCS_LINE_BYTES_LOG2 = 7;
endpackage

// File: rtl/lcs_index.sv
module lcs_index #(
    parameter int WHITEN_W = 10,
    parameter int SLOT_W   = 6,
    parameter int LINE_W   = 4,
    parameter int LINE_LSB = 7,
    parameter int ADDR_W   = 32,
    localparam int IDX_W   = SLOT_W + LINE_W
) (
    input  logic [WHITEN_W-1:0] whiten,
    input  logic [ADDR_W-1:0]   addr,
    output logic [IDX_W-1:0]    idx
);
    logic [SLOT_W-1:0] slot;
    logic [LINE_W-1:0] line;

    assign slot = whiten[WHITEN_W-1 -: SLOT_W];
    assign line = addr[LINE_LSB +: LINE_W];
    assign idx  = {slot, line};
endmodule

// File: rtl/lcs_sram.sv
module lcs_sram #(
    parameter int IDX_W = 10,
    parameter int DAT_W = 16,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  lcs_pkg::tbl_op_e op,
    input  logic [IDX_W-1:0] idx,
    input  logic [DAT_W-1:0] wdata,
    output logic [DAT_W-1:0] rdata
);
    logic [DAT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (op == lcs_pkg::OP_WRITE) begin
            mem[idx] <= wdata;
        end else if (op == lcs_pkg::OP_READ) begin
            rdata <= mem[idx];
        end
    end
endmodule

// File: rtl/line_crc_store.sv
module line_crc_store
    import lcs_pkg::*;
#(
    parameter int WHITEN_W = 10,
    parameter int SLOT_W   = 6,
    parameter int LINE_W   = 4,
    parameter int LINE_LSB = LCS_LINE_BYTES_LOG2,
    parameter int ADDR_W   = 32,
    parameter int CRC_W    = 16,
    parameter int THREADS  = 8,
    parameter int TID_W    = $clog2(THREADS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fill_valid,
    output logic                fill_ready,
    input  logic [WHITEN_W-1:0] fill_whiten,
    input  logic [ADDR_W-1:0]   fill_addr,
    input  logic [CRC_W-1:0]    fill_crc,
    input  logic [TID_W-1:0]    fill_tid,
    input  logic                wb_valid,
    input  logic [WHITEN_W-1:0] wb_whiten,
    input  logic [ADDR_W-1:0]   wb_addr,
    input  logic [CRC_W-1:0]    wb_crc,
    output logic                res_valid,
    output logic                res_pass,
    output logic [TID_W-1:0]    res_tid,
    output logic [THREADS-1:0]  thread_halt
);
    localparam int IDX_W = SLOT_W + LINE_W;
    localparam int HW    = 1 << TID_W;

    typedef struct packed {
        logic             pend_v;
        logic [IDX_W-1:0] pend_idx;
        logic [CRC_W-1:0] pend_crc;
        logic [TID_W-1:0] pend_tid;
        logic             s1_v;
        logic [CRC_W-1:0] s1_crc;
        logic [TID_W-1:0] s1_tid;
        logic             res_v;
        logic             res_pass;
        logic [TID_W-1:0] res_tid;
        logic [HW-1:0]    halted;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0] fill_idx, wb_idx, tbl_idx;
    logic [CRC_W-1:0] tbl_rdata;
    tbl_op_e          tbl_op;
    logic             fill_take;
    logic             rd_v;
    logic [IDX_W-1:0] rd_idx;
    logic [CRC_W-1:0] rd_crc;
    logic [TID_W-1:0] rd_tid;

    lcs_index #(
        .WHITEN_W(WHITEN_W), .SLOT_W(SLOT_W), .LINE_W(LINE_W),
        .LINE_LSB(LINE_LSB), .ADDR_W(ADDR_W)
    ) u_fill_idx (
        .whiten(fill_whiten), .addr(fill_addr), .idx(fill_idx)
    );

    lcs_index #(
        .WHITEN_W(WHITEN_W), .SLOT_W(SLOT_W), .LINE_W(LINE_W),
        .LINE_LSB(LINE_LSB), .ADDR_W(ADDR_W)
    ) u_wb_idx (
        .whiten(wb_whiten), .addr(wb_addr), .idx(wb_idx)
    );

    lcs_sram #(.IDX_W(IDX_W), .DAT_W(CRC_W)) u_tbl (
        .clk(clk), .op(tbl_op), .idx(tbl_idx), .wdata(wb_crc), .rdata(tbl_rdata)
    );

    always_comb begin
        st_d       = st_q;
        st_d.s1_v  = 1'b0;
        st_d.res_v = 1'b0;

        // a fill is taken when nothing is held and its thread is alive
        fill_take = fill_valid && !st_q.pend_v && !st_q.halted[fill_tid];

        // the held fill always goes before a new one
        rd_v   = st_q.pend_v || fill_take;
        rd_idx = st_q.pend_v ? st_q.pend_idx : fill_idx;
        rd_crc = st_q.pend_v ? st_q.pend_crc : fill_crc;
        rd_tid = st_q.pend_v ? st_q.pend_tid : fill_tid;

        tbl_op  = OP_IDLE;
        tbl_idx = rd_idx;

        if (wb_valid) begin
            // write owns the single port; park the read
            tbl_op  = OP_WRITE;
            tbl_idx = wb_idx;
            if (fill_take) begin
                st_d.pend_v   = 1'b1;
                st_d.pend_idx = fill_idx;
                st_d.pend_crc = fill_crc;
                st_d.pend_tid = fill_tid;
            end
        end else if (rd_v) begin
            tbl_op      = OP_READ;
            st_d.pend_v = 1'b0;
            st_d.s1_v   = 1'b1;
            st_d.s1_crc = rd_crc;
            st_d.s1_tid = rd_tid;
        end

        if (st_q.s1_v) begin
            st_d.res_v    = 1'b1;
            st_d.res_pass = (tbl_rdata == st_q.s1_crc);
            st_d.res_tid  = st_q.s1_tid;
            if (tbl_rdata != st_q.s1_crc) begin
                st_d.halted[st_q.s1_tid] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fill_ready  = !st_q.pend_v;
    assign res_valid   = st_q.res_v;
    assign res_pass    = st_q.res_pass;
    assign res_tid     = st_q.res_tid;
    assign thread_halt = st_q.halted[THREADS-1:0];
endmodule

// File: rtl/lcs_checker.sv
module lcs_checker #(
    parameter int THREADS = 8,
    parameter int TID_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fill_valid,
    input logic               fill_ready,
    input logic [TID_W-1:0]   fill_tid,
    input logic               wb_valid,
    input logic               res_valid,
    input logic               res_pass,
    input logic [TID_W-1:0]   res_tid,
    input logic [THREADS-1:0] thread_halt
);
    // R8: halt flags never clear outside reset
    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(|($past(thread_halt) & ~thread_halt)));

    // R8: a fail pulse comes with the thread's halt bit set
    a_r8_fail_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_pass) |-> thread_halt[res_tid]);

    // R5: an accepted fill with a free port answers two cycles later
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_ready && !wb_valid && !thread_halt[fill_tid])
        |-> ##2 (res_valid && res_tid == $past(fill_tid, 2)));

    // R7: a colliding fill blocks new fills for one cycle
    a_r7_collide_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_ready && wb_valid && !thread_halt[fill_tid]) |=> !fill_ready);

    // R7: a held fill leaves as soon as the port is free
    a_r7_hold_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_ready && !wb_valid) |=> fill_ready);
endmodule

bind line_crc_store lcs_checker #(.THREADS(THREADS), .TID_W(TID_W)) u_lcs_chk (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_tid(fill_tid), .wb_valid(wb_valid), .res_valid(res_valid),
    .res_pass(res_pass), .res_tid(res_tid), .thread_halt(thread_halt)
);

// File: tb/sim_line_crc_store.sv
module sim_line_crc_store;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_valid = 1'b0;
    logic        fill_ready;
    logic [9:0]  fill_whiten = '0;
    logic [31:0] fill_addr = '0;
    logic [15:0] fill_crc = '0;
    logic [2:0]  fill_tid = '0;
    logic        wb_valid = 1'b0;
    logic [9:0]  wb_whiten = '0;
    logic [31:0] wb_addr = '0;
    logic [15:0] wb_crc = '0;
    logic        res_valid;
    logic        res_pass;
    logic [2:0]  res_tid;
    logic [7:0]  thread_halt;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int n_res = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic [2:0] tid;
        logic       pass;
        string      req;
    } exp_t;
    exp_t sb[$];

    line_crc_store u0 (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_whiten(fill_whiten),
        .fill_addr(fill_addr), .fill_crc(fill_crc), .fill_tid(fill_tid),
        .wb_valid(wb_valid), .wb_whiten(wb_whiten), .wb_addr(wb_addr), .wb_crc(wb_crc),
        .res_valid(res_valid), .res_pass(res_pass), .res_tid(res_tid),
        .thread_halt(thread_halt)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: every result pulse must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            n_res++;
            if (sb.size() == 0) begin
                check(1'b0, "R9 unexpected result", {res_tid, res_pass}, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(cyc == e.at, {e.req, " cycle"}, cyc, e.at);
                check(res_tid == e.tid, {e.req, " tid"}, res_tid, e.tid);
                check(res_pass == e.pass, {e.req, " pass"}, res_pass, e.pass);
            end
        end
    end

    task automatic push(input int at, input logic [2:0] tid, input logic pass, input string req);
        exp_t e;
        e.at = at; e.tid = tid; e.pass = pass; e.req = req;
        sb.push_back(e);
    endtask

    task automatic do_wb(input logic [9:0] w, input logic [31:0] a, input logic [15:0] c);
        wb_valid = 1'b1; wb_whiten = w; wb_addr = a; wb_crc = c;
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic do_fill(input logic [9:0] w, input logic [31:0] a, input logic [15:0] c,
                           input logic [2:0] t, input bit exp_out, input logic pass,
                           input string req);
        fill_valid = 1'b1; fill_whiten = w; fill_addr = a; fill_crc = c; fill_tid = t;
        if (exp_out) push(cyc + 2, t, pass, req);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
        check(thread_halt == 8'h00, "R1 thread_halt", thread_halt, 0);
        check(fill_ready == 1'b1, "R1 fill_ready", fill_ready, 1);

        // R3 / R5 / R10: store then read next cycle
        do_wb(10'h2B3, 32'h0000_0180, 16'h1234);
        do_fill(10'h2B3, 32'h0000_0180, 16'h1234, 3'd1, 1, 1'b1, "R3");
        idle(3);

        // R4 / R8: single-bit difference fails and halts thread 4
        do_fill(10'h2B3, 32'h0000_0180, 16'h1235, 3'd4, 1, 1'b0, "R4");
        idle(3);
        check(thread_halt == 8'h10, "R8 halt set", thread_halt, 8'h10);

        // R2: other whitening low bits and out-of-field address bits alias
        do_fill(10'h2BC, 32'hABC0_01FF, 16'h1234, 3'd0, 1, 1'b1, "R2");
        idle(3);

        // R6: same line, three slots, independent contents
        do_wb(10'h050, 32'h0000_0180, 16'hAAAA);
        do_wb(10'h060, 32'h0000_0180, 16'h5555);
        do_fill(10'h050, 32'h0000_0180, 16'hAAAA, 3'd2, 1, 1'b1, "R6 slot5");
        do_fill(10'h060, 32'h0000_0180, 16'h5555, 3'd3, 1, 1'b1, "R6 slot6");
        do_fill(10'h2B0, 32'h0000_0180, 16'h1234, 3'd1, 1, 1'b1, "R6 slot43");
        idle(3);

        // R7: write and fill to the same entry in one cycle
        base = cyc;
        wb_valid = 1'b1; wb_whiten = 10'h050; wb_addr = 32'h0000_0180; wb_crc = 16'hBEEF;
        fill_valid = 1'b1; fill_whiten = 10'h050; fill_addr = 32'h0000_0180;
        fill_crc = 16'hBEEF; fill_tid = 3'd2;
        push(base + 3, 3'd2, 1'b1, "R7");
        @(negedge clk);
        wb_valid = 1'b0; fill_valid = 1'b0;
        check(fill_ready == 1'b0, "R7 ready low", fill_ready, 0);
        @(negedge clk);
        check(fill_ready == 1'b1, "R7 ready back", fill_ready, 1);
        idle(3);

        // R8: halt bit survives later passing results
        check(thread_halt == 8'h10, "R8 sticky", thread_halt, 8'h10);

        // R9: fill from halted thread 4 is dropped
        base = n_res;
        do_fill(10'h2B3, 32'h0000_0180, 16'h1234, 3'd4, 0, 1'b0, "R9");
        idle(5);
        check(n_res == base, "R9 no result", n_res, base);
        check(thread_halt == 8'h10, "R9 halt unchanged", thread_halt, 8'h10);
        do_fill(10'h2B3, 32'h0000_0180, 16'h1234, 3'd3, 1, 1'b1, "R9 other thread");
        idle(3);

        // R10: overwrite, old value fails, new value passes
        do_wb(10'h060, 32'h0000_0180, 16'h7777);
        do_fill(10'h060, 32'h0000_0180, 16'h5555, 3'd5, 1, 1'b0, "R10 old");
        do_fill(10'h060, 32'h0000_0180, 16'h7777, 3'd6, 1, 1'b1, "R10 new");
        idle(4);
        check(thread_halt == 8'h30, "R10 halt 5", thread_halt, 8'h30);

        check(sb.size() == 0, "R5 all results seen", sb.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=0", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule